// File: doc/BRIEF.md
# Four-Channel PWM Generator with Paired Prescalers

The block produces four independent pulse-width modulated outputs. The reference clock reaches each channel through three stages. The first stage is an 8-bit prescaler that one pair of channels shares. The second is a per-channel power-of-two divider chosen by a 3-bit code. The last is a 16-bit down-counter that sets the period. A 16-bit compare value sets how many counts of each period the output is high. Per-channel control bits turn the channel on, invert its output and choose between a single period (one-shot) and a repeating waveform.

Software reaches the block through a simple 32-bit word register port. Writes take effect on the next clock edge, and reads are combinational from the address. New period and compare values only take effect at a period boundary, so the running waveform never sees a partial update. Each channel can flag a pending interrupt at the end of each period. The flags are cleared by writing ones, and `irq_o` is the OR of all flags.

Top module: `pwm_bank`

## Requirements
- R1: After reset, every register reads 0, `pwm_o` is 0 and `irq_o` is 0.
- R2: Registers read back the written bits, and unused bits read 0. Addresses: 0x00 prescalers, 0x04 divider codes, 0x08 control, 0x0C interrupt enable (bits 3:0), 0x10 pending (bits 3:0), 0x20+8·n period of channel n, 0x24+8·n compare of channel n. Writing all ones gives 0x0000FFFF, 0x00007777, 0x000FFF0F, 0xF, 0x0000FFFF and 0x0000FFFF respectively.
- R3: Prescaler bits [7:0] serve channels 0 and 1, and bits [15:8] serve channels 2 and 3. Each divides the clock by its value plus one.
- R4: Channel n has a divider code in bits [4n+2:4n]. Codes 0, 1, 2 and 3 divide by 2, 4, 8 and 16. Code 4, and the unused codes 5 to 7, divide by 1.
- R5: In continuous mode the output period is (prescaler+1)·divider·(period+1) clock cycles.
- R6: The output is high for (compare+1)·(prescaler+1)·divider cycles of each period. When compare ≥ period, the output stays high.
- R7: A period value of 0 keeps the output at its idle level and never sets a pending flag.
- R8: Channel n's control field starts at bit 0, 8, 12 or 16 for n = 0..3. Field bit 0 is enable, field bit 2 is invert, and field bit 3 is mode (1 = continuous, 0 = one-shot). Invert complements the output in every state, so an idle channel drives its invert bit.
- R9: In one-shot mode the channel runs exactly one period, sets its pending flag once, and then stays idle until it is re-enabled.
- R10: New period and compare values written while a channel runs take effect only at its next period boundary.
- R11: A channel whose enable bit is set raises its pending flag at each period end. Writing 1 to a pending bit clears it, and `irq_o` is high while any flag is pending.
- R12: A disabled channel drives its invert level, starting one clock after the enable bit clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| pwm_o | output | 4 | PWM outputs, one per channel |
| irq_o | output | 1 | OR of the pending flags |

## Verification
Faults in the prescaler, divider or down-counter appear on `pwm_o` as a wrong high time or a wrong period within one output period, so the bench measures both in clock cycles. A shadow register loaded too early changes the pulse already in progress, and this shows in the first high time after the write. A lost enable edge or a missing one-shot stop shows as extra pulses or extra pending flags within a few periods. The checker separately catches any pending flag that sets with interrupts disabled or clears without a write.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int NUM_CH   = 4;
  localparam int NUM_PAIR = NUM_CH / 2;
  localparam int PSC_W    = 8;
  localparam int SEL_W    = 3;
  localparam int DIV_W    = 4;
  localparam int CNT_W    = 16;
  localparam int ADDR_W   = 8;
  localparam int DATA_W   = 32;
  localparam int CTRL_W   = 4;

  localparam logic [ADDR_W-1:0] ADR_PSC  = 8'h00;
  localparam logic [ADDR_W-1:0] ADR_SEL  = 8'h04;
  localparam logic [ADDR_W-1:0] ADR_CTRL = 8'h08;
  localparam logic [ADDR_W-1:0] ADR_IE   = 8'h0C;
  localparam logic [ADDR_W-1:0] ADR_PEND = 8'h10;
  localparam logic [ADDR_W-1:0] ADR_PER0 = 8'h20;
  localparam logic [ADDR_W-1:0] ADR_CMP0 = 8'h24;

  // control fields are not evenly spaced: 0, 8, 12, 16
  function automatic int ctrl_lsb(int c);
    return (c == 0) ? 0 : 4 + 4 * c;
  endfunction

  function automatic logic [ADDR_W-1:0] per_adr(int c);
    return ADR_PER0 + ADDR_W'(8 * c);
  endfunction

  function automatic logic [ADDR_W-1:0] cmp_adr(int c);
    return ADR_CMP0 + ADDR_W'(8 * c);
  endfunction

  function automatic logic [DATA_W-1:0] psc_mask();
    logic [DATA_W-1:0] m = '0;
    for (int p = 0; p < NUM_PAIR; p++) m[p*PSC_W +: PSC_W] = '1;
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] sel_mask();
    logic [DATA_W-1:0] m = '0;
    for (int c = 0; c < NUM_CH; c++) m[4*c +: SEL_W] = '1;
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] ctrl_mask();
    logic [DATA_W-1:0] m = '0;
    for (int c = 0; c < NUM_CH; c++) m[ctrl_lsb(c) +: CTRL_W] = '1;
    return m;
  endfunction

  // terminal value of the divider counter (divide ratio minus one)
  function automatic logic [DIV_W-1:0] div_last(logic [SEL_W-1:0] code);
    case (code)
      3'd0:    return DIV_W'(1);
      3'd1:    return DIV_W'(3);
      3'd2:    return DIV_W'(7);
      3'd3:    return DIV_W'(15);
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int W = pwm_pkg::PSC_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] psc_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;

  // >= keeps the wrap safe when the limit is lowered below the count
  assign tick_o = (cnt_q >= psc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int DW = DIV_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             psc_tick_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             en_i,
  input  logic             inv_i,
  input  logic             cont_i,
  input  logic [CW-1:0]    per_i,
  input  logic [CW-1:0]    cmp_i,
  output logic             pwm_o,
  output logic             period_end_o
);
  logic          en_q, run_q;
  logic [DW-1:0] dcnt_q, dlast;
  logic [CW-1:0] cnt_q, per_q, cmp_q;
  logic          ch_tick, at_end, active;

  assign dlast   = DW'(div_last(sel_i));
  assign ch_tick = run_q && psc_tick_i && (dcnt_q >= dlast);
  assign at_end  = ch_tick && (cnt_q == '0);

  assign period_end_o = at_end && en_i && en_q && (per_q != '0);

  assign active = run_q && (per_q != '0) &&
                  ((cmp_q >= per_q) || (cnt_q <= cmp_q));
  assign pwm_o  = active ^ inv_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      run_q  <= 1'b0;
      dcnt_q <= '0;
      cnt_q  <= '0;
      per_q  <= '0;
      cmp_q  <= '0;
    end else begin
      en_q <= en_i;
      if (!en_i) begin
        run_q  <= 1'b0;
        cnt_q  <= '0;
        dcnt_q <= '0;
      end else if (!en_q) begin
        run_q  <= 1'b1;
        cnt_q  <= per_i;
        per_q  <= per_i;
        cmp_q  <= cmp_i;
        dcnt_q <= '0;
      end else if (run_q && psc_tick_i) begin
        dcnt_q <= (dcnt_q >= dlast) ? '0 : dcnt_q + 1'b1;
        if (ch_tick) begin
          if (cnt_q == '0) begin
            if (cont_i) begin
              cnt_q <= per_i;
              per_q <= per_i;
              cmp_q <= cmp_i;
            end else begin
              run_q <= 1'b0;
            end
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
(
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            wr_en_i,
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic [DATA_W-1:0]               wdata_i,
  output logic [DATA_W-1:0]               rdata_o,
  input  logic [NUM_CH-1:0]               period_end_i,
  output logic [NUM_PAIR-1:0][PSC_W-1:0]  psc_o,
  output logic [NUM_CH-1:0][SEL_W-1:0]    sel_o,
  output logic [NUM_CH-1:0]               en_o,
  output logic [NUM_CH-1:0]               inv_o,
  output logic [NUM_CH-1:0]               cont_o,
  output logic [NUM_CH-1:0][CNT_W-1:0]    per_o,
  output logic [NUM_CH-1:0][CNT_W-1:0]    cmp_o,
  output logic [NUM_CH-1:0]               ie_o,
  output logic [NUM_CH-1:0]               pend_o
);
  localparam logic [DATA_W-1:0] PSC_M  = psc_mask();
  localparam logic [DATA_W-1:0] SEL_M  = sel_mask();
  localparam logic [DATA_W-1:0] CTRL_M = ctrl_mask();

  logic [DATA_W-1:0] psc_q, sel_q, ctrl_q;
  logic [NUM_CH-1:0] ie_q, pend_q;
  logic [NUM_CH-1:0][CNT_W-1:0] per_q, cmp_q;
  logic clr_hit;

  assign clr_hit = wr_en_i && (addr_i == ADR_PEND);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psc_q  <= '0;
      sel_q  <= '0;
      ctrl_q <= '0;
      ie_q   <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        ADR_PSC:  psc_q  <= wdata_i & PSC_M;
        ADR_SEL:  sel_q  <= wdata_i & SEL_M;
        ADR_CTRL: ctrl_q <= wdata_i & CTRL_M;
        ADR_IE:   ie_q   <= wdata_i[NUM_CH-1:0];
        default: ;
      endcase
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int L = ctrl_lsb(c);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        per_q[c] <= '0;
        cmp_q[c] <= '0;
      end else if (wr_en_i) begin
        if (addr_i == per_adr(c)) per_q[c] <= wdata_i[CNT_W-1:0];
        if (addr_i == cmp_adr(c)) cmp_q[c] <= wdata_i[CNT_W-1:0];
      end
    end

    // a new event wins over a simultaneous clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_q[c] <= 1'b0;
      else if (period_end_i[c] && ie_q[c]) pend_q[c] <= 1'b1;
      else if (clr_hit && wdata_i[c]) pend_q[c] <= 1'b0;
    end

    assign sel_o[c]  = sel_q[4*c +: SEL_W];
    assign en_o[c]   = ctrl_q[L];
    assign inv_o[c]  = ctrl_q[L+2];
    assign cont_o[c] = ctrl_q[L+3];
  end

  for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
    assign psc_o[p] = psc_q[p*PSC_W +: PSC_W];
  end

  assign per_o  = per_q;
  assign cmp_o  = cmp_q;
  assign ie_o   = ie_q;
  assign pend_o = pend_q;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADR_PSC:  rdata_o = psc_q;
      ADR_SEL:  rdata_o = sel_q;
      ADR_CTRL: rdata_o = ctrl_q;
      ADR_IE:   rdata_o = DATA_W'(ie_q);
      ADR_PEND: rdata_o = DATA_W'(pend_q);
      default: ;
    endcase
    for (int c = 0; c < NUM_CH; c++) begin
      if (addr_i == per_adr(c)) rdata_o = DATA_W'(per_q[c]);
      if (addr_i == cmp_adr(c)) rdata_o = DATA_W'(cmp_q[c]);
    end
  end
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NUM_CH-1:0] pwm_o,
  output logic              irq_o
);
  logic [NUM_PAIR-1:0][PSC_W-1:0] psc_w;
  logic [NUM_CH-1:0][SEL_W-1:0]   sel_w;
  logic [NUM_CH-1:0][CNT_W-1:0]   per_w, cmp_w;
  logic [NUM_CH-1:0] en_w, inv_w, cont_w, ie_w, pend_w, end_w;
  logic [NUM_PAIR-1:0] tick_w;

  pwm_regs i_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .addr_i       (addr_i),
    .wdata_i      (wdata_i),
    .rdata_o      (rdata_o),
    .period_end_i (end_w),
    .psc_o        (psc_w),
    .sel_o        (sel_w),
    .en_o         (en_w),
    .inv_o        (inv_w),
    .cont_o       (cont_w),
    .per_o        (per_w),
    .cmp_o        (cmp_w),
    .ie_o         (ie_w),
    .pend_o       (pend_w)
  );

  for (genvar p = 0; p < NUM_PAIR; p++) begin : g_psc
    pwm_prescaler #(.W(PSC_W)) i_psc (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .psc_i  (psc_w[p]),
      .tick_o (tick_w[p])
    );
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pwm_channel #(.CW(CNT_W), .DW(DIV_W)) i_ch (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .psc_tick_i   (tick_w[c/2]),
      .sel_i        (sel_w[c]),
      .en_i         (en_w[c]),
      .inv_i        (inv_w[c]),
      .cont_i       (cont_w[c]),
      .per_i        (per_w[c]),
      .cmp_i        (cmp_w[c]),
      .pwm_o        (pwm_o[c]),
      .period_end_o (end_w[c])
    );
  end

  assign irq_o = |pend_w;
endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk
  import pwm_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [NUM_CH-1:0] wdata_i,
  input logic [NUM_CH-1:0] en_i,
  input logic [NUM_CH-1:0] inv_i,
  input logic [NUM_CH-1:0] ie_i,
  input logic [NUM_CH-1:0] pend_i,
  input logic [NUM_CH-1:0] pwm_i
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_a
    a_r12_disabled_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en_i[c] && $past(!en_i[c])) |-> (pwm_i[c] == inv_i[c]));

    a_r11_set_needs_ie: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pend_i[c]) |-> $past(ie_i[c]));

    a_r11_set_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pend_i[c]) |-> $past(en_i[c]));

    a_r11_clear_by_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(pend_i[c]) |-> $past(wr_en_i && (addr_i == ADR_PEND) && wdata_i[c]));
  end
endmodule

bind pwm_bank pwm_bank_chk i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i[pwm_pkg::NUM_CH-1:0]),
  .en_i    (en_w),
  .inv_i   (inv_w),
  .ie_i    (ie_w),
  .pend_i  (pend_w),
  .pwm_i   (pwm_o)
);

// File: tb/test_pwm_bank.sv
module test_pwm_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  pwm;
  logic        irq;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] psc_sh = '0, sel_sh = '0, ctrl_sh = '0;

  always #2 clk = ~clk;

  pwm_bank i_pwm_bank (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pwm_o(pwm), .irq_o(irq)
  );

  typedef struct packed {
    logic [1:0]  ch;
    logic [7:0]  psc;
    logic [2:0]  code;
    logic [15:0] per;
    logic [15:0] cmp;
    logic        inv;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{2'd0, 8'd0, 3'd4, 16'd9, 16'd3, 1'b0},
    '{2'd1, 8'd2, 3'd0, 16'd4, 16'd1, 1'b0},
    '{2'd2, 8'd1, 3'd1, 16'd3, 16'd0, 1'b1},
    '{2'd3, 8'd0, 3'd3, 16'd2, 16'd1, 1'b0},
    '{2'd0, 8'd0, 3'd2, 16'd1, 16'd0, 1'b0},
    '{2'd3, 8'd3, 3'd6, 16'd7, 16'd5, 1'b1}
  };

  function automatic int ratio(logic [2:0] code);
    case (code)
      3'd0: return 2;
      3'd1: return 4;
      3'd2: return 8;
      3'd3: return 16;
      default: return 1;
    endcase
  endfunction

  function automatic int cpos(int ch);
    return (ch == 0) ? 0 : 4 * ch + 4;
  endfunction

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic cfg(int ch, int psc, int code, int per, int cmp, bit inv, bit cont);
    ctrl_sh[cpos(ch) +: 4] = 4'b0;
    wr(8'h08, ctrl_sh);
    psc_sh[8*(ch/2) +: 8] = 8'(psc);
    wr(8'h00, psc_sh);
    sel_sh[4*ch +: 3] = 3'(code);
    wr(8'h04, sel_sh);
    wr(8'(8'h20 + 8*ch), 32'(per));
    wr(8'(8'h24 + 8*ch), 32'(cmp));
    ctrl_sh[cpos(ch)] = 1'b1;
    ctrl_sh[cpos(ch)+2] = inv;
    ctrl_sh[cpos(ch)+3] = cont;
    wr(8'h08, ctrl_sh);
  endtask

  task automatic disable_ch(int ch);
    ctrl_sh[cpos(ch)] = 1'b0;
    wr(8'h08, ctrl_sh);
  endtask

  task automatic wait_level(int ch, bit inv, bit lvl);
    bit prev = pwm[ch] ^ inv;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (prev != lvl && (pwm[ch] ^ inv) == lvl) return;
      prev = pwm[ch] ^ inv;
    end
    check("edge timeout", 0, 1);
  endtask

  task automatic run_len(int ch, bit inv, bit lvl, output int n);
    n = 1;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if ((pwm[ch] ^ inv) != lvl) return;
      n++;
    end
  endtask

  task automatic count_hi(int ch, int cyc, output int h);
    h = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      h += int'(pwm[ch]);
    end
  endtask

  initial begin
    #600000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int hi, lo, hi2, exp_unit;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 pwm", pwm, 0);
    check("R1 irq", irq, 0);
    rd(8'h00, d); check("R1 psc", d, 0);
    rd(8'h08, d); check("R1 ctrl", d, 0);
    rd(8'h20, d); check("R1 per0", d, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: readback and unused bits
    wr(8'h00, '1); rd(8'h00, d); check("R2 psc", d, 32'h0000FFFF);
    wr(8'h04, '1); rd(8'h04, d); check("R2 sel", d, 32'h00007777);
    wr(8'h08, '1); rd(8'h08, d); check("R2 ctrl", d, 32'h000FFF0F);
    wr(8'h0C, '1); rd(8'h0C, d); check("R2 ie", d, 32'hF);
    wr(8'h28, '1); rd(8'h28, d); check("R2 per1", d, 32'h0000FFFF);
    wr(8'h3C, 32'h1234ABCD); rd(8'h3C, d); check("R2 cmp3", d, 32'h0000ABCD);
    wr(8'h08, 0); wr(8'h00, 0); wr(8'h04, 0); wr(8'h0C, 0);
    wr(8'h28, 0); wr(8'h3C, 0);
    rd(8'h10, d); check("R7 no pend with zero period", d, 0);

    // R3 R4 R5 R6 R8: table walk
    for (int v = 0; v < 6; v++) begin
      cfg(VECS[v].ch, VECS[v].psc, VECS[v].code, VECS[v].per, VECS[v].cmp, VECS[v].inv, 1'b1);
      exp_unit = (VECS[v].psc + 1) * ratio(VECS[v].code);
      wait_level(VECS[v].ch, VECS[v].inv, 1'b1);
      run_len(VECS[v].ch, VECS[v].inv, 1'b1, hi);
      run_len(VECS[v].ch, VECS[v].inv, 1'b0, lo);
      check($sformatf("R6 R8 high time vec%0d", v), hi, exp_unit * (VECS[v].cmp + 1));
      check($sformatf("R5 R3 R4 period vec%0d", v), hi + lo, exp_unit * (VECS[v].per + 1));
    end
    for (int c = 0; c < 4; c++) disable_ch(c);

    // R12: disabled channel drives invert level
    ctrl_sh[cpos(3)+2] = 1'b1; wr(8'h08, ctrl_sh);
    @(negedge clk);
    check("R12 disabled inv=1", pwm[3], 1);
    ctrl_sh[cpos(3)+2] = 1'b0; wr(8'h08, ctrl_sh);
    @(negedge clk);
    check("R12 disabled inv=0", pwm[3], 0);

    // R6: compare >= period keeps output high
    cfg(1, 0, 4, 5, 5, 0, 1); repeat (3) @(negedge clk);
    count_hi(1, 40, hi); check("R6 cmp==per", hi, 40);
    cfg(1, 0, 4, 5, 9, 0, 1); repeat (3) @(negedge clk);
    count_hi(1, 40, hi); check("R6 cmp>per", hi, 40);
    disable_ch(1);

    // R7: zero period
    wr(8'h0C, 32'h4); wr(8'h10, 32'hF);
    cfg(2, 0, 4, 0, 0, 0, 1);
    count_hi(2, 40, hi); check("R7 zero period output", hi, 0);
    rd(8'h10, d); check("R7 zero period pend", d, 0);
    disable_ch(2);

    // R9: one-shot
    wr(8'h0C, 32'h2); wr(8'h10, 32'hF);
    cfg(1, 0, 4, 4, 1, 0, 0);
    count_hi(1, 40, hi); check("R9 one-shot high count", hi, 2);
    rd(8'h10, d); check("R9 one-shot pend", d, 32'h2);
    check("R11 irq while pending", irq, 1);
    wr(8'h10, 32'h2);
    count_hi(1, 30, hi); check("R9 idle after one-shot", hi, 0);
    rd(8'h10, d); check("R9 single event", d, 0);
    check("R11 irq cleared", irq, 0);
    disable_ch(1);

    // R10: shadow update at boundary
    cfg(0, 0, 4, 9, 5, 0, 1);
    wait_level(0, 0, 1'b0);
    wr(8'h20, 32'd19); wr(8'h24, 32'd7);
    wait_level(0, 0, 1'b1);
    run_len(0, 0, 1'b1, hi);
    run_len(0, 0, 1'b0, lo);
    run_len(0, 0, 1'b1, hi2);
    check("R10 old compare kept", hi, 6);
    check("R10 new high", hi2, 8);
    check("R10 new period", lo + hi2, 20);

    // R11: pending with enable, none without
    wr(8'h0C, 32'h1); wr(8'h10, 32'hF);
    cfg(1, 0, 4, 3, 1, 0, 1);
    repeat (30) @(negedge clk);
    rd(8'h10, d); check("R11 pend ch0 only", d, 32'h1);
    check("R11 irq high", irq, 1);
    disable_ch(0); disable_ch(1);
    wr(8'h10, 32'h1);
    rd(8'h10, d); check("R11 w1c", d, 0);
    check("R11 irq low", irq, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule